// File: doc/BRIEF.md
# Load Data Alignment and Extension Unit

This unit sits between a 64-bit data memory read port and the register file writeback path. Each load request carries a byte address, an access size of 8, 16, 32 or 64 bits, a signed or unsigned select, and a big-endian mode bit that software sets at runtime. The unit captures the request together with the aligned 64-bit doubleword read from memory. It picks out the addressed bytes and orders them for the selected endianness. It then widens the value to 64 bits, with sign extension or zero extension.

An access whose address is not a multiple of its own size is not performed. The unit raises a fault flag for that request and holds the register write enable low. Every request gives exactly one response in the cycle after its strobe. That response is either a register write or a fault.

Top module: `lda_load_align`

## Requirements
- R1: While reset is asserted and after it is released, `rsp_valid`, `rsp_wr_en` and `misalign_fault` are low and `rsp_data` is zero until the first request is captured.
- R2: A request present on `req_valid` at a rising clock edge makes `rsp_valid` high for exactly the next clock period; in a cycle that follows an edge without `req_valid`, `rsp_valid` is low.
- R3: The byte at address offset a (a = `req_addr[2:0]`) occupies `mem_rdata[8a+7:8a]`; address bits above bit 2 have no effect on the result.
- R4: With `big_endian` = 0, the byte at the lowest address of the access becomes the least significant byte of the value.
- R5: With `big_endian` = 1, the byte at the lowest address of the access becomes the most significant byte of the value.
- R6: `req_size` encodes the access width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits.
- R7: With `req_unsigned` = 0, every result bit above the access width equals the top bit of the loaded value.
- R8: With `req_unsigned` = 1, result bits above the access width are zero; for 64-bit loads the select has no effect.
- R9: An access of N bytes is aligned when `req_addr[2:0]` is a multiple of N; 8-bit accesses are always aligned.
- R10: A misaligned request drives `misalign_fault` high for its single response cycle, with `rsp_wr_en` low and `rsp_data` zero.
- R11: An aligned request drives `rsp_wr_en` high in its response cycle, with `misalign_fault` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Load request strobe |
| req_addr | input | ADDR_W | Byte address of the load |
| req_size | input | 2 | Access width code |
| req_unsigned | input | 1 | 1 = zero-extend, 0 = sign-extend |
| big_endian | input | 1 | Byte order mode, 1 = big-endian |
| mem_rdata | input | 64 | Aligned doubleword read from memory |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_data | output | 64 | Extended load result |
| rsp_wr_en | output | 1 | Register file write enable |
| misalign_fault | output | 1 | Misaligned access flag |

## Verification
The assertions check some properties on every cycle. Every strobe is followed by exactly one response. A response is either a write or a fault and never both. A fault never carries data or a write enable. Byte loads never fault. The upper result bits are zero for unsigned byte loads and copy the sign bit for signed halfword loads. Two things can be shown only by the bench's sweep, which covers every offset, size, signedness and byte order with several data patterns: the exact byte order produced by each endian mode, and the fact that high address bits have no influence.

// File: rtl/lda_pkg.sv
package lda_pkg;
  localparam int LANES   = 8;
  localparam int DWORD_W = 8 * LANES;
  localparam int OFF_W   = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } ld_size_e;

  // Width of an access in bytes
  function automatic int size_bytes(ld_size_e sz);
    return 1 << int'(sz);
  endfunction

  // Order the low n bytes of an offset-shifted doubleword
  function automatic logic [DWORD_W-1:0] lane_order(logic [DWORD_W-1:0] shifted,
                                                     ld_size_e sz, logic big);
    logic [DWORD_W-1:0] res;
    int n;
    n   = size_bytes(sz);
    res = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < n) begin
        if (big) res[8*i +: 8] = shifted[8*(n-1-i) +: 8];
        else     res[8*i +: 8] = shifted[8*i +: 8];
      end
    end
    return res;
  endfunction

  // Widen an n-byte value to the full doubleword
  function automatic logic [DWORD_W-1:0] widen(logic [DWORD_W-1:0] v,
                                                ld_size_e sz, logic uns);
    logic [DWORD_W-1:0] res;
    case (sz)
      SZ_B:    res = {{(DWORD_W-8){v[7]  & ~uns}}, v[7:0]};
      SZ_H:    res = {{(DWORD_W-16){v[15] & ~uns}}, v[15:0]};
      SZ_W:    res = {{(DWORD_W-32){v[31] & ~uns}}, v[31:0]};
      default: res = v;
    endcase
    return res;
  endfunction

  // Offset not a multiple of the access size
  function automatic logic is_misaligned(logic [OFF_W-1:0] off, ld_size_e sz);
    logic [OFF_W-1:0] mask;
    mask = OFF_W'(size_bytes(sz) - 1);
    return |(off & mask);
  endfunction
endpackage

// File: rtl/lda_align_chk.sv
module lda_align_chk
  import lda_pkg::*;
(
  input  logic [OFF_W-1:0] off,
  input  ld_size_e         size,
  output logic             misaligned
);
  always_comb misaligned = is_misaligned(off, size);
endmodule

// File: rtl/lda_lane_pick.sv
module lda_lane_pick
  import lda_pkg::*;
(
  input  logic [DWORD_W-1:0] dword,
  input  logic [OFF_W-1:0]   off,
  input  ld_size_e           size,
  input  logic               big,
  output logic [DWORD_W-1:0] value
);
  logic [DWORD_W-1:0] shifted;

  // Bring the addressed lane down to byte 0
  always_comb shifted = dword >> {off, 3'b000};
  always_comb value   = lane_order(shifted, size, big);
endmodule

// File: rtl/lda_extend.sv
module lda_extend
  import lda_pkg::*;
(
  input  logic [DWORD_W-1:0] value,
  input  ld_size_e           size,
  input  logic               uns,
  output logic [DWORD_W-1:0] result
);
  always_comb result = widen(value, size, uns);
endmodule

// File: rtl/lda_load_align.sv
module lda_load_align
  import lda_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic              big_endian,
  input  logic [63:0]       mem_rdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_data,
  output logic              rsp_wr_en,
  output logic              misalign_fault
);
  // Captured request
  logic               vld_q;
  logic [OFF_W-1:0]   off_q;
  ld_size_e           size_q;
  logic               uns_q;
  logic               big_q;
  logic [DWORD_W-1:0] data_q;

  // Named internal events
  logic               misal;
  logic [DWORD_W-1:0] lane_val;
  logic [DWORD_W-1:0] ext_val;
  logic               addr_hi_unused;

  assign addr_hi_unused = ^req_addr[ADDR_W-1:OFF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      off_q  <= '0;
      size_q <= SZ_B;
      uns_q  <= 1'b0;
      big_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= req_valid;
      if (req_valid) begin
        off_q  <= req_addr[OFF_W-1:0];
        size_q <= ld_size_e'(req_size);
        uns_q  <= req_unsigned;
        big_q  <= big_endian;
        data_q <= mem_rdata;
      end
    end
  end

  lda_align_chk u_chk (
    .off        (off_q),
    .size       (size_q),
    .misaligned (misal)
  );

  lda_lane_pick u_pick (
    .dword (data_q),
    .off   (off_q),
    .size  (size_q),
    .big   (big_q),
    .value (lane_val)
  );

  lda_extend u_ext (
    .value  (lane_val),
    .size   (size_q),
    .uns    (uns_q),
    .result (ext_val)
  );

  assign rsp_valid      = vld_q;
  assign misalign_fault = vld_q & misal;
  assign rsp_wr_en      = vld_q & ~misal;
  assign rsp_data       = (vld_q & ~misal) ? ext_val : '0;

  // R2: each strobe yields a response next cycle, none otherwise
  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R10: a fault carries no write and no data
  assert_fault_blocks_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_fault |-> (!rsp_wr_en && rsp_data == '0));

  // R11: a response is either a write or a fault
  assert_outcome_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_wr_en, misalign_fault}) == 1));
  assert_no_outcome_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_wr_en && !misalign_fault));

  // R9: byte loads never fault
  assert_byte_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && size_q == SZ_B) |-> !misalign_fault);

  // R8: unsigned byte load leaves upper bits clear
  assert_unsigned_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_wr_en && uns_q && size_q == SZ_B) |-> (rsp_data[63:8] == '0));

  // R7: signed halfword load copies its sign into the upper bits
  assert_signed_upper_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_wr_en && !uns_q && size_q == SZ_H) |->
      (($countones(rsp_data[63:15]) == 0) || ($countones(rsp_data[63:15]) == 49)));
endmodule

// File: tb/sim_lda_load_align.sv
module sim_lda_load_align;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_size = '0;
  logic              req_unsigned = 1'b0;
  logic              big_endian = 1'b0;
  logic [63:0]       mem_rdata = '0;
  logic              rsp_valid;
  logic [63:0]       rsp_data;
  logic              rsp_wr_en;
  logic              misalign_fault;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lda_load_align #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_unsigned(req_unsigned), .big_endian(big_endian),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_wr_en(rsp_wr_en), .misalign_fault(misalign_fault)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected load result computed arithmetically
  function automatic logic [63:0] model(logic [63:0] d, int off, int sz, bit uns, bit big);
    int nb;
    logic [63:0] v;
    logic [63:0] byte_v;
    nb = 1 << sz;
    v  = 0;
    for (int k = 0; k < nb; k++) begin
      byte_v = 64'(d[8*(off+k) +: 8]);
      if (big) v = v + (byte_v << (8*(nb-1-k)));
      else     v = v + (byte_v << (8*k));
    end
    if (sz < 3 && !uns && v[8*nb-1]) v = v | ~((64'd1 << (8*nb)) - 64'd1);
    return v;
  endfunction

  task automatic one_load(logic [63:0] d, int off, int sz, bit uns, bit big, logic [28:0] hi);
    bit mis;
    string dtag;
    @(negedge clk);
    req_valid    = 1'b1;
    req_addr     = {hi, 3'(off)};     // R3: high bits vary
    req_size     = 2'(sz);            // R6 encoding
    req_unsigned = uns;
    big_endian   = big;
    mem_rdata    = d;
    @(negedge clk);
    req_valid = 1'b0;
    mis = (off % (1 << sz)) != 0;     // R9
    check("R2 rsp_valid", 64'(rsp_valid), 64'd1);
    if (mis) begin
      check("R10 fault", 64'(misalign_fault), 64'd1);
      check("R10 wr_en", 64'(rsp_wr_en), 64'd0);
      check("R10 data", rsp_data, 64'd0);
    end else begin
      dtag = $sformatf("%s/%s/R3 data off=%0d sz=%0d",
                       big ? "R5" : "R4", uns ? "R8" : "R7", off, sz);
      check("R11 wr_en", 64'(rsp_wr_en), 64'd1);
      check("R11 fault", 64'(misalign_fault), 64'd0);
      check(dtag, rsp_data, model(d, off, sz, uns, big));
    end
  endtask

  initial begin
    logic [63:0] pats [4];
    pats[0] = 64'h8877_6655_4433_2211;
    pats[1] = 64'h0F1E_2D3C_4B5A_6978;
    pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[3] = 64'h7F80_01FE_807F_FF00;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1 wr_en", 64'(rsp_wr_en), 64'd0);
    check("R1 fault", 64'(misalign_fault), 64'd0);
    check("R1 data", rsp_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 64'(rsp_valid), 64'd0);
    for (int p = 0; p < 4; p++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 8; off++)
          for (int m = 0; m < 4; m++) begin
            one_load(pats[p], off, sz, m[0], m[1], 29'(p * 12345 + off * 777 + m));
            // R2: no strobe, no response
            @(negedge clk);
            check("R2 idle", 64'({rsp_valid, rsp_wr_en, misalign_fault}), 64'd0);
          end
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule